// File: doc/BRIEF.md
# Shared Mailbox Aperture with Ownership Handoff

This block is the device-side model of a 256-bit mailbox window that two parties share. A requester fills eight 32-bit dwords over a simple register write port. A servicer on the other side picks up the request and posts a reply. Only one party owns the window at any time. The owner is shown in the top bit of the highest dword, so one read of that dword tells a polling requester whether it may write again.

When the requester writes the highest dword, the whole window passes to the servicer in that same clock edge. The servicer is told by a one-cycle pulse and sees all eight dwords in parallel. Its reply overwrites the highest dword and clears the owner bit, which gives the window back to the requester. A request can be as short as one write to the highest dword, with the lower dwords left as they were. While the requester's function is held in reset, every requester read returns all ones. A poller can tell that state apart from either ownership value.

Top module: `mbox_aperture`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), all eight dwords read zero, the owner flag is 0 (requester owns), and sv_req_valid and rq_wr_blocked are low.
- R2: While the requester owns the window, a write to dword index 0 to 6 stores the write data unchanged, and it reads back at that index on the next cycle.
- R3: While the requester owns the window, a write to dword index 7 stores the data with bit 31 forced to 1, and the owner flag reads 1 (servicer owns) from the next cycle.
- R4: sv_req_valid is high for exactly one cycle, the cycle after each accepted write to dword 7, and at no other time.
- R5: While the servicer owns the window, requester writes to any index leave all dwords unchanged, and rq_wr_blocked is high for one cycle after each such write.
- R6: While the servicer owns the window, a response strobe loads dword 7 with the response data with bit 31 forced to 0. The requester owns the window from the next cycle, and dwords 0 to 6 are untouched.
- R7: A response strobe while the requester owns the window changes nothing.
- R8: While fn_in_reset is high, rq_rd_data is 0xFFFFFFFF at every read index. Normal readback returns when it drops, and the stored contents are kept.
- R9: sv_aperture carries dword i on bits [32*i+31 : 32*i], and sv_owner equals bit 255 of that bus.
- R10: A single write to dword 7 with no preceding writes to the lower dwords performs a full handoff, and the lower dwords keep their earlier values.
- R11: If a requester write and a response strobe arrive in the same cycle while the servicer owns the window, the response is applied and the requester write is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fn_in_reset | input | 1 | Requester function in reset; reads return all ones |
| rq_wr_en | input | 1 | Requester write strobe |
| rq_wr_addr | input | 3 | Requester write dword index |
| rq_wr_data | input | 32 | Requester write data |
| rq_rd_addr | input | 3 | Requester read dword index |
| rq_rd_data | output | 32 | Requester read data (combinational) |
| rq_wr_blocked | output | 1 | One-cycle flag: a write was refused because the servicer owns the window |
| sv_rsp_wr | input | 1 | Servicer response strobe |
| sv_rsp_data | input | 32 | Servicer response header for dword 7 |
| sv_req_valid | output | 1 | One-cycle pulse after each handoff to the servicer |
| sv_owner | output | 1 | Current owner flag (1 = servicer) |
| sv_aperture | output | 256 | All eight dwords in parallel |

## Verification
The bench targets the ownership edges. These are a write to dword 7 that must set the flag even when its data has bit 31 clear, and a response whose data has bit 31 set that must still return the window. A design that copied bit 31 through would leave the window stuck with one party or hand it over early. Blocked writes, including a second write to dword 7, are checked for both the lack of a store and the absence of a second request pulse. A design that honoured them would corrupt a pending request or retrigger the servicer. The bench also covers the same-cycle collision of reply and write, a bare teardown-style handoff, and reset readback at every index. A design that applied the reset override only to dword 7 fails that last case.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int DW      = 32;
  parameter int NWORDS  = 8;
  localparam int AW     = $clog2(NWORDS);
  localparam int LAST   = NWORDS - 1;
  localparam int OWNB   = DW - 1;
  localparam int FLATW  = DW * NWORDS;

  typedef logic [DW-1:0] dword_t;
  typedef logic [AW-1:0] didx_t;

  // Word stored when the requester hands the window over.
  function automatic dword_t handoff_word(input dword_t d);
    return {1'b1, d[OWNB-1:0]};
  endfunction

  // Word stored when the servicer hands the window back.
  function automatic dword_t response_word(input dword_t d);
    return {1'b0, d[OWNB-1:0]};
  endfunction

  // Bit offset of dword i in the flat view.
  function automatic int word_lsb(input int i);
    return i * DW;
  endfunction
endpackage

// File: rtl/mbox_owner_track.sv
module mbox_owner_track
  import mbox_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  owner_sv,
  input  logic  wr_en,
  input  didx_t wr_addr,
  input  logic  rsp_wr,
  output logic  accept_wr,
  output logic  handoff,
  output logic  rsp_take,
  output logic  blocked,
  output logic  req_valid_q,
  output logic  blocked_q
);
  assign accept_wr = wr_en && !owner_sv;
  assign blocked   = wr_en && owner_sv;
  assign rsp_take  = rsp_wr && owner_sv;
  assign handoff   = accept_wr && (wr_addr == didx_t'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid_q <= 1'b0;
      blocked_q   <= 1'b0;
    end else begin
      req_valid_q <= handoff;
      blocked_q   <= blocked;
    end
  end
endmodule

// File: rtl/mbox_dword_bank.sv
module mbox_dword_bank
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_wr,
  input  didx_t            wr_addr,
  input  dword_t           wr_data,
  input  logic             rsp_take,
  input  dword_t           rsp_data,
  output logic [FLATW-1:0] flat
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_dw
    dword_t q;
    logic   hit;
    assign hit = accept_wr && (wr_addr == didx_t'(i));
    if (i == LAST) begin : g_ctl
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (rsp_take) q <= response_word(rsp_data);
        else if (hit)      q <= handoff_word(wr_data);
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
    end
    assign flat[word_lsb(i) +: DW] = q;
  end
endmodule

// File: rtl/mbox_read_mux.sv
module mbox_read_mux
  import mbox_pkg::*;
(
  input  logic [FLATW-1:0] flat,
  input  didx_t            rd_addr,
  input  logic             fn_in_reset,
  output dword_t           rd_data
);
  dword_t sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < NWORDS; i++)
      if (rd_addr == didx_t'(i)) sel = flat[word_lsb(i) +: DW];
  end
  assign rd_data = fn_in_reset ? '1 : sel;
endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture
  import mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fn_in_reset,
  input  logic               rq_wr_en,
  input  logic [AW-1:0]      rq_wr_addr,
  input  logic [DW-1:0]      rq_wr_data,
  input  logic [AW-1:0]      rq_rd_addr,
  output logic [DW-1:0]      rq_rd_data,
  output logic               rq_wr_blocked,
  input  logic               sv_rsp_wr,
  input  logic [DW-1:0]      sv_rsp_data,
  output logic               sv_req_valid,
  output logic               sv_owner,
  output logic [FLATW-1:0]   sv_aperture
);
  logic             accept_wr, handoff, rsp_take, blocked;
  logic [FLATW-1:0] flat;

  assign sv_owner    = flat[FLATW-1];
  assign sv_aperture = flat;

  mbox_owner_track u_own (
    .clk(clk), .rst_n(rst_n), .owner_sv(sv_owner),
    .wr_en(rq_wr_en), .wr_addr(rq_wr_addr), .rsp_wr(sv_rsp_wr),
    .accept_wr(accept_wr), .handoff(handoff), .rsp_take(rsp_take),
    .blocked(blocked), .req_valid_q(sv_req_valid), .blocked_q(rq_wr_blocked)
  );

  mbox_dword_bank u_bank (
    .clk(clk), .rst_n(rst_n), .accept_wr(accept_wr), .wr_addr(rq_wr_addr),
    .wr_data(rq_wr_data), .rsp_take(rsp_take), .rsp_data(sv_rsp_data),
    .flat(flat)
  );

  mbox_read_mux u_rd (
    .flat(flat), .rd_addr(rq_rd_addr), .fn_in_reset(fn_in_reset),
    .rd_data(rq_rd_data)
  );
endmodule

// File: rtl/mbox_aperture_chk.sv
module mbox_aperture_chk
  import mbox_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fn_in_reset,
  input logic             rq_wr_en,
  input logic [AW-1:0]    rq_wr_addr,
  input logic [DW-1:0]    rq_rd_data,
  input logic             rq_wr_blocked,
  input logic             sv_rsp_wr,
  input logic             sv_req_valid,
  input logic             sv_owner,
  input logic [FLATW-1:0] sv_aperture,
  input logic             handoff,
  input logic             rsp_take
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sv_aperture == '0));

  assert_handoff_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_wr_en && !sv_owner && rq_wr_addr == AW'(LAST)) |=> sv_owner);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sv_req_valid |=> !sv_req_valid);

  assert_pulse_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> sv_req_valid);

  assert_blocked_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_wr_en && sv_owner && !sv_rsp_wr) |=> ($stable(sv_aperture) && rq_wr_blocked));

  assert_rsp_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> !sv_owner);

  assert_rsp_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_rsp_wr && !sv_owner && !rq_wr_en) |=> $stable(sv_aperture));

  assert_reset_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fn_in_reset |-> (rq_rd_data == '1));

  assert_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_wr_en && sv_rsp_wr && sv_owner) |=> (!sv_owner && !sv_req_valid));
endmodule

bind mbox_aperture mbox_aperture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fn_in_reset(fn_in_reset), .rq_wr_en(rq_wr_en),
  .rq_wr_addr(rq_wr_addr), .rq_rd_data(rq_rd_data), .rq_wr_blocked(rq_wr_blocked),
  .sv_rsp_wr(sv_rsp_wr), .sv_req_valid(sv_req_valid), .sv_owner(sv_owner),
  .sv_aperture(sv_aperture), .handoff(handoff), .rsp_take(rsp_take)
);

// File: tb/test_mbox_aperture.sv
`timescale 1ns/1ps
module test_mbox_aperture;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fn_in_reset = 1'b0;
  logic         rq_wr_en = 1'b0;
  logic [2:0]   rq_wr_addr = '0;
  logic [31:0]  rq_wr_data = '0;
  logic [2:0]   rq_rd_addr = '0;
  logic [31:0]  rq_rd_data;
  logic         rq_wr_blocked;
  logic         sv_rsp_wr = 1'b0;
  logic [31:0]  sv_rsp_data = '0;
  logic         sv_req_valid;
  logic         sv_owner;
  logic [255:0] sv_aperture;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  logic [31:0] m_word [8];
  bit          m_rv, m_bl;

  always #2 clk = ~clk;

  mbox_aperture i_mbox_aperture (
    .clk(clk), .rst_n(rst_n), .fn_in_reset(fn_in_reset),
    .rq_wr_en(rq_wr_en), .rq_wr_addr(rq_wr_addr), .rq_wr_data(rq_wr_data),
    .rq_rd_addr(rq_rd_addr), .rq_rd_data(rq_rd_data), .rq_wr_blocked(rq_wr_blocked),
    .sv_rsp_wr(sv_rsp_wr), .sv_rsp_data(sv_rsp_data), .sv_req_valid(sv_req_valid),
    .sv_owner(sv_owner), .sv_aperture(sv_aperture)
  );

  task automatic chk(input string tag, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit own;
    own = m_word[7][31];
    m_rv = 0; m_bl = 0;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_word[i] = 32'h0;
    end else if (own) begin
      if (rq_wr_en) m_bl = 1;
      if (sv_rsp_wr) m_word[7] = sv_rsp_data & 32'h7FFF_FFFF;
    end else if (rq_wr_en) begin
      if (rq_wr_addr == 3'd7) begin
        m_word[7] = rq_wr_data | 32'h8000_0000;
        m_rv = 1;
      end else m_word[rq_wr_addr] = rq_wr_data;
    end
  endtask

  // One clock: drive, step model at the edge, compare at the falling edge.
  task automatic cyc(input string tag, input bit we, input logic [2:0] wa,
                     input logic [31:0] wd, input bit rsp, input logic [31:0] rd,
                     input logic [2:0] ra, input bit fr);
    logic [255:0] flat;
    rq_wr_en = we; rq_wr_addr = wa; rq_wr_data = wd;
    sv_rsp_wr = rsp; sv_rsp_data = rd; rq_rd_addr = ra; fn_in_reset = fr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int i = 0; i < 8; i++) flat[i*32 +: 32] = m_word[i];
    chk(tag, "aperture", sv_aperture, flat);
    chk(tag, "owner", 256'(sv_owner), 256'(m_word[7][31]));
    chk(tag, "req_valid", 256'(sv_req_valid), 256'(m_rv));
    chk(tag, "wr_blocked", 256'(rq_wr_blocked), 256'(m_bl));
    chk(tag, "rd_data", 256'(rq_rd_data), 256'(fr ? 32'hFFFF_FFFF : m_word[ra]));
  endtask

  task automatic idle(input string tag, input logic [2:0] ra);
    cyc(tag, 0, 3'd0, 32'h0, 0, 32'h0, ra, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_word[i] = 32'hDEAD_BEEF;
    @(negedge clk);
    rst_n = 0;
    idle("R1", 3'd0);
    idle("R1", 3'd7);
    rst_n = 1;
    for (int a = 0; a < 8; a++) idle("R1", 3'(a));

    // R2: fill the lower dwords and read each back
    for (int a = 0; a < 7; a++)
      cyc("R2", 1, 3'(a), 32'h1000_0000 + 32'(a) * 32'h0101_1111, 0, 0, 3'(a), 0);
    // R9: parallel view and per-index readback
    for (int a = 0; a < 8; a++) idle("R9", 3'(a));

    // R3/R4: handoff with bit 31 clear in the data
    cyc("R3", 1, 3'd7, 32'h0000_0041, 0, 0, 3'd7, 0);
    idle("R4", 3'd7);

    // R5: writes while servicer owns, including a second dword-7 write
    cyc("R5", 1, 3'd2, 32'hAAAA_5555, 0, 0, 3'd2, 0);
    cyc("R5", 1, 3'd7, 32'h0000_0099, 0, 0, 3'd7, 0);
    idle("R5", 3'd7);

    // R8: reset readback while servicer owns, every index
    for (int a = 0; a < 8; a++) cyc("R8", 0, 0, 0, 0, 0, 3'(a), 1);
    idle("R8", 3'd7);

    // R6: response with bit 31 set in its data still releases
    cyc("R6", 0, 0, 0, 1, 32'hFFFF_0005, 3'd7, 0);
    idle("R6", 3'd0);

    // R7: response while requester owns
    cyc("R7", 0, 0, 0, 1, 32'h1234_5678, 3'd7, 0);
    idle("R7", 3'd7);

    // R10: teardown-style single write
    cyc("R10", 1, 3'd7, 32'h0000_0002, 0, 0, 3'd7, 0);
    for (int a = 0; a < 8; a++) idle("R10", 3'(a));

    // R11: response and requester write collide
    cyc("R11", 1, 3'd4, 32'h5A5A_5A5A, 1, 32'h0000_0102, 3'd4, 0);
    idle("R11", 3'd7);
    cyc("R11", 1, 3'd4, 32'h5A5A_5A5A, 0, 0, 3'd4, 0);

    // R8: override lifts and contents survive with requester owning
    cyc("R8", 0, 0, 0, 0, 0, 3'd4, 1);
    idle("R8", 3'd4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule